// File: doc/BRIEF.md
# CAN Receive Identifier Acceptance Filter

This block decides whether a received CAN frame may enter a receive FIFO. Each frame arrives as a descriptor holding a 29-bit identifier, an extended-frame flag and a remote-frame flag. The block compares the descriptor against eight 32-bit filter words. A global format field decides how each word is read: as one full-identifier filter, as two 14-bit partial filters, or as four 8-bit partial filters. That gives 8, 16 or 32 filters. The block returns an accept flag and the index of the lowest-numbered matching filter.

The frame descriptor enters on a valid/ready handshake. The verdict leaves on a second valid/ready handshake with one register stage between the two. The block takes a new frame only when its output register is empty or is being drained in the same cycle (`in_ready = !res_valid || res_ready`). A held verdict stays unchanged until `res_ready` is seen high. Filter words and the format field are written through a plain write-only register port. The format field changes only while `freeze` is high.

Top module: `acf_filter`

## Requirements
- R1: Register port. Addresses 0 to 7 write filter words 0 to 7, and writes to the table are taken at any time. Address 8 bits [1:0] write the format: 0 means full-ID filters, 1 means two 14-bit filters per word, 2 means four 8-bit filters per word, and 3 means no filter matches. After reset the format is 0 and every word is zero.
- R2: A write to the format address while `freeze` is low is ignored, and filtering keeps the previous format.
- R3: In format 0, filter *w* is word *w*. Bit 31 is its remote select, bit 30 its extended select and bits [28:0] its ID. An extended frame compares all 29 bits with `in_id`. A standard frame compares field bits [28:18] with `in_id[10:0]`.
- R4: In format 1, filter 2w uses bits [31:16] of word *w* and filter 2w+1 uses bits [15:0]. In each half, bit 15 is remote select, bit 14 is extended select and [13:0] is the ID. An extended frame compares [13:0] with `in_id[28:15]`. A standard frame compares [13:3] with `in_id[10:0]`.
- R5: In format 2, filter 4w+k uses byte k of word *w*, where byte 0 is bits [31:24] and byte 3 is bits [7:0]. The byte is compared with `in_id[28:21]` for extended frames and with `in_id[10:3]` for standard frames. Remote and extended flags do not restrict these filters.
- R6: A filter whose remote select is 0 matches only data frames. A filter whose remote select is 1 matches only remote frames.
- R7: A filter whose extended select is 0 matches only standard frames. A filter whose extended select is 1 matches only extended frames.
- R8: When several filters match, `res_idx` reports the lowest-numbered one.
- R9: A frame taken at a clock edge has its verdict on `res_valid`/`res_accept`/`res_idx` after that same edge. With `res_ready` high, `res_valid` lasts one cycle. A frame that matches nothing gives `res_accept` = 0 and `res_idx` = 0.
- R10: While `res_valid` is high and `res_ready` is low, the verdict holds steady and `in_ready` is low.
- R11: For standard frames, `in_id[28:11]` does not affect the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| freeze | input | 1 | Permits format changes when high |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address (0-7 table, 8 format) |
| cfg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Frame descriptor valid |
| in_ready | output | 1 | Block can take a descriptor |
| in_id | input | 29 | Received identifier (standard ID in [10:0]) |
| in_ext | input | 1 | Frame is extended |
| in_rtr | input | 1 | Frame is remote |
| res_valid | output | 1 | Verdict valid |
| res_ready | input | 1 | Consumer takes the verdict |
| res_accept | output | 1 | Frame matched a filter |
| res_idx | output | 5 | Index of the winning filter |

## Verification
Two situations are hard to reach from the ports: several filters matching the same frame, and identifiers that differ only in bits outside the compared slice. Random identifiers almost never match a random table. The stimulus therefore builds each frame from a chosen filter's own fields and fills the uncompared bits with random values. It also copies entries between words, and between halves or bytes of one word, so the priority encoder has to choose between filters in the same word and filters in different words. Each built frame is then varied: its remote flag is flipped, its extended flag is flipped, one bit inside the compared slice is flipped, and one bit below the slice is flipped.

// File: rtl/acf_pkg.sv
package acf_pkg;
  localparam int ID_W   = 29;
  localparam int STD_W  = 11;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;
  localparam int PART_W = 14;
  localparam int BYTE_W = 8;
  localparam int SLOTS  = 4;

  typedef enum logic [1:0] {
    FMT_FULL = 2'd0,
    FMT_HALF = 2'd1,
    FMT_BYTE = 2'd2,
    FMT_OFF  = 2'd3
  } acf_fmt_e;
endpackage

// File: rtl/acf_cfg_regs.sv
module acf_cfg_regs #(
  parameter int NUM_WORDS = 8,
  parameter int ADDR_W    = 4
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      freeze,
  input  logic                                      cfg_we,
  input  logic [ADDR_W-1:0]                         cfg_addr,
  input  logic [acf_pkg::WORD_W-1:0]                cfg_wdata,
  output logic [NUM_WORDS-1:0][acf_pkg::WORD_W-1:0] table_q,
  output acf_pkg::acf_fmt_e                         mode_q
);
  import acf_pkg::*;
  localparam int MODE_ADDR = NUM_WORDS;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        table_q[w] <= '0;
      else if (cfg_we && cfg_addr == ADDR_W'(w))
        table_q[w] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      mode_q <= FMT_FULL;
    else if (cfg_we && freeze && cfg_addr == ADDR_W'(MODE_ADDR))
      mode_q <= acf_fmt_e'(cfg_wdata[1:0]);
  end
endmodule

// File: rtl/acf_word_match.sv
module acf_word_match (
  input  logic [acf_pkg::WORD_W-1:0] word,
  input  acf_pkg::acf_fmt_e          fmt,
  input  logic [acf_pkg::ID_W-1:0]   id,
  input  logic                       ext,
  input  logic                       rtr,
  output logic [acf_pkg::SLOTS-1:0]  hit
);
  import acf_pkg::*;
  localparam int NHALF = WORD_W / HALF_W;
  localparam int NBYTE = WORD_W / BYTE_W;

  logic             full_hit;
  logic [NHALF-1:0] half_hit;
  logic [NBYTE-1:0] byte_hit;

  // full-identifier filter: qualifiers in the two top bits, ID in [28:0]
  always_comb begin
    full_hit = (word[WORD_W-1] == rtr) && (word[WORD_W-2] == ext);
    if (ext)
      full_hit = full_hit && (word[ID_W-1:0] == id);
    else
      full_hit = full_hit && (word[ID_W-1 -: STD_W] == id[STD_W-1:0]);
  end

  // two partial filters per word, slot 0 in the upper half
  for (genvar h = 0; h < NHALF; h++) begin : g_half
    logic [HALF_W-1:0] hw;
    assign hw = word[WORD_W-1-HALF_W*h -: HALF_W];
    always_comb begin
      half_hit[h] = (hw[HALF_W-1] == rtr) && (hw[HALF_W-2] == ext);
      if (ext)
        half_hit[h] = half_hit[h] && (hw[PART_W-1:0] == id[ID_W-1 -: PART_W]);
      else
        half_hit[h] = half_hit[h] && (hw[PART_W-1 -: STD_W] == id[STD_W-1:0]);
    end
  end

  // four byte filters per word, slot 0 in the top byte, no qualifiers
  for (genvar k = 0; k < NBYTE; k++) begin : g_byte
    logic [BYTE_W-1:0] bw;
    assign bw = word[WORD_W-1-BYTE_W*k -: BYTE_W];
    assign byte_hit[k] = ext ? (bw == id[ID_W-1 -: BYTE_W])
                             : (bw == id[STD_W-1 -: BYTE_W]);
  end

  always_comb begin
    hit = '0;
    unique case (fmt)
      FMT_FULL: hit[0]       = full_hit;
      FMT_HALF: hit[NHALF-1:0] = half_hit;
      FMT_BYTE: hit          = byte_hit;
      default:  hit          = '0;
    endcase
  end
endmodule

// File: rtl/acf_prio.sv
module acf_prio #(
  parameter int N     = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/acf_filter.sv
module acf_filter #(
  parameter int NUM_WORDS = 8,
  parameter int ADDR_W    = 4,
  parameter int IDX_W     = $clog2(NUM_WORDS * acf_pkg::SLOTS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       freeze,
  input  logic                       cfg_we,
  input  logic [ADDR_W-1:0]          cfg_addr,
  input  logic [acf_pkg::WORD_W-1:0] cfg_wdata,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [acf_pkg::ID_W-1:0]   in_id,
  input  logic                       in_ext,
  input  logic                       in_rtr,
  output logic                       res_valid,
  input  logic                       res_ready,
  output logic                       res_accept,
  output logic [IDX_W-1:0]           res_idx
);
  import acf_pkg::*;
  localparam int NFILT = NUM_WORDS * SLOTS;

  logic [NUM_WORDS-1:0][WORD_W-1:0] table_q;
  acf_fmt_e                         mode_q;
  logic [NUM_WORDS-1:0][SLOTS-1:0]  hit;
  logic [NFILT-1:0]                 ordered;
  logic                             found;
  logic [IDX_W-1:0]                 win_idx;
  logic                             take;

  acf_cfg_regs #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .freeze   (freeze),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .table_q  (table_q),
    .mode_q   (mode_q)
  );

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_match
    acf_word_match u_match (
      .word(table_q[w]),
      .fmt (mode_q),
      .id  (in_id),
      .ext (in_ext),
      .rtr (in_rtr),
      .hit (hit[w])
    );
  end

  // place each slot hit at its filter number for the active format
  always_comb begin
    ordered = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      unique case (mode_q)
        FMT_FULL: ordered[w] = hit[w][0];
        FMT_HALF: begin
          ordered[2*w]   = hit[w][0];
          ordered[2*w+1] = hit[w][1];
        end
        FMT_BYTE: begin
          for (int k = 0; k < SLOTS; k++)
            ordered[SLOTS*w+k] = hit[w][k];
        end
        default: ;
      endcase
    end
  end

  acf_prio #(.N(NFILT), .IDX_W(IDX_W)) u_prio (
    .vec  (ordered),
    .found(found),
    .idx  (win_idx)
  );

  assign in_ready = !res_valid || res_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_idx    <= '0;
    end else if (take) begin
      res_valid  <= 1'b1;
      res_accept <= found;
      res_idx    <= found ? win_idx : '0;
    end else if (res_ready) begin
      res_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/acf_checker.sv
module acf_checker #(
  parameter int NUM_WORDS = 8,
  parameter int ADDR_W    = 4,
  parameter int IDX_W     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              freeze,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic              in_valid,
  input logic              in_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic              res_accept,
  input logic [IDX_W-1:0]  res_idx,
  input logic [1:0]        mode_q
);
  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> res_valid);

  assert_noaccept_idx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_accept) |-> (res_idx == '0));

  assert_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(res_valid) |-> $past(res_ready));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_accept) && $stable(res_idx)));

  assert_modelock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !freeze && cfg_addr == ADDR_W'(NUM_WORDS)) |=> $stable(mode_q));

  assert_full_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && mode_q == 2'd0) |=> (!res_accept || res_idx < IDX_W'(NUM_WORDS)));

  assert_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && mode_q == 2'd3) |=> !res_accept);
endmodule

bind acf_filter acf_checker #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .freeze    (freeze),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_accept(res_accept),
  .res_idx   (res_idx),
  .mode_q    (mode_q)
);

// File: tb/sim_acf_filter.sv
module sim_acf_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        freeze = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [28:0] in_id = '0;
  logic        in_ext = 1'b0;
  logic        in_rtr = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_accept;
  logic [4:0]  res_idx;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1234_5678;
  logic [31:0] tbl [8];
  logic [1:0]  sh_mode = 2'd0;

  always #4 clk = ~clk;

  acf_filter u0 (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .in_valid(in_valid),
    .in_ready(in_ready), .in_id(in_id), .in_ext(in_ext), .in_rtr(in_rtr),
    .res_valid(res_valid), .res_ready(res_ready), .res_accept(res_accept),
    .res_idx(res_idx)
  );

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected verdict from the requirements (R1 R3 R4 R5 R6 R7 R8 R11)
  function automatic void model(input logic [28:0] id, input logic ext, input logic rtr,
                                output logic acc, output logic [4:0] ix);
    acc = 1'b0;
    ix  = '0;
    for (int f = 31; f >= 0; f--) begin
      logic m;
      logic [31:0] w;
      logic [15:0] h;
      logic [7:0]  b;
      m = 1'b0;
      case (sh_mode)
        2'd0: if (f < 8) begin
          w = tbl[f];
          m = (w[31] == rtr) && (w[30] == ext) &&
              (ext ? (w[28:0] == id) : (w[28:18] == id[10:0]));
        end
        2'd1: if (f < 16) begin
          w = tbl[f/2];
          h = (f % 2 == 0) ? w[31:16] : w[15:0];
          m = (h[15] == rtr) && (h[14] == ext) &&
              (ext ? (h[13:0] == id[28:15]) : (h[13:3] == id[10:0]));
        end
        2'd2: begin
          w = tbl[f/4];
          b = w[8*(3 - f%4) +: 8];
          m = ext ? (b == id[28:21]) : (b == id[10:3]);
        end
        default: m = 1'b0;
      endcase
      if (m) begin
        acc = 1'b1;
        ix  = 5'(f);
      end
    end
  endfunction

  // frame built from filter f of format fmt, then varied by v
  task automatic make_frame(input int fmt, input int f, input int v,
                            output logic [28:0] id, output logic ext, output logic rtr);
    logic [31:0] r;
    logic [31:0] r2;
    logic [31:0] w;
    logic [15:0] h;
    logic [7:0]  b;
    int pos;
    r  = rnd();
    r2 = rnd();
    pos = -1;
    case (fmt)
      0: begin
        w = tbl[f % 8];
        ext = w[30]; rtr = w[31];
        id = ext ? w[28:0] : {r[17:0], w[28:18]};
      end
      1: begin
        w = tbl[f/2];
        h = (f % 2 == 0) ? w[31:16] : w[15:0];
        ext = h[14]; rtr = h[15];
        id = ext ? {h[13:0], r[14:0]} : {r[17:0], h[13:3]};
      end
      default: begin
        w = tbl[f/4];
        b = w[8*(3 - f%4) +: 8];
        ext = r[30]; rtr = r[31];
        id = ext ? {b, r[20:0]} : {r[17:0], b, r[2:0]};
      end
    endcase
    case (v)
      1: rtr = ~rtr;
      2: ext = ~ext;
      3: begin
        if (ext) pos = (fmt == 0) ? int'(r2 % 29) : (fmt == 1) ? 15 + int'(r2 % 14) : 21 + int'(r2 % 8);
        else     pos = (fmt == 2) ? 3 + int'(r2 % 8) : int'(r2 % 11);
      end
      4: begin
        if (ext) pos = (fmt == 0) ? -1 : (fmt == 1) ? int'(r2 % 15) : int'(r2 % 21);
        else     pos = 11 + int'(r2 % 18);
      end
      default: ;
    endcase
    if (pos >= 0) id[pos] = ~id[pos];
  endtask

  task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a < 4'd8) tbl[a[2:0]] = d;
    else if (a == 4'd8 && freeze) sh_mode = d[1:0];
  endtask

  task automatic set_mode(input logic [1:0] m);
    freeze = 1'b1;
    cfg_write(4'd8, {30'd0, m});
    freeze = 1'b0;
  endtask

  task automatic send_check(string tag, logic [28:0] id, logic ext, logic rtr);
    logic ea;
    logic [4:0] ei;
    logic [6:0] first;
    logic second;
    model(id, ext, rtr, ea, ei);
    @(negedge clk);
    in_valid = 1'b1; in_id = id; in_ext = ext; in_rtr = rtr;
    @(negedge clk);
    in_valid = 1'b0;
    first = {res_valid, res_accept, res_idx};
    @(negedge clk);
    second = res_valid;
    check(tag, {first, second}, {1'b1, ea, ei, 1'b0});
  endtask

  task automatic fill_table();
    for (int w = 0; w < 8; w++) tbl[w] = rnd();
    tbl[6] = tbl[1];                 // cross-word duplicate
    tbl[4][15:0] = tbl[4][31:16];    // same-word halves
    tbl[5][15:8] = tbl[5][31:24];    // same-word bytes
    tbl[3][31:24] = tbl[0][23:16];   // cross-word byte
    for (int w = 0; w < 8; w++) cfg_write(4'(w), tbl[w]);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [28:0] id;
    logic ext, rtr;
    logic [6:0] snap;
    for (int w = 0; w < 8; w++) tbl[w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R9: reset state of the handshake
    check("R1 reset", {res_valid, in_ready}, {1'b0, 1'b1});
    // R1: zero table in format 0 matches a standard data frame with ID 0
    send_check("R1 reset table", 29'h1FFF_F800, 1'b0, 1'b0);
    send_check("R1 reset table ext", 29'd0, 1'b1, 1'b0);

    for (int m = 0; m < 3; m++) begin
      int nf;
      set_mode(2'(m));
      nf = (m == 0) ? 8 : (m == 1) ? 16 : 32;
      for (int t = 0; t < 3; t++) begin
        fill_table();
        for (int f = 0; f < nf; f++)
          for (int v = 0; v < 5; v++) begin
            make_frame(m, f, v, id, ext, rtr);
            case (m)
              0: send_check("R3/R6/R7/R8/R11", id, ext, rtr);
              1: send_check("R4/R6/R7/R8/R11", id, ext, rtr);
              default: send_check("R5/R8/R11", id, ext, rtr);
            endcase
          end
      end
    end

    // R2: format write without freeze is ignored
    set_mode(2'd0);
    fill_table();
    cfg_write(4'd8, 32'd2);
    for (int f = 0; f < 8; f++) begin
      make_frame(0, f, 0, id, ext, rtr);
      send_check("R2", id, ext, rtr);
    end

    // R1: format 3 accepts nothing
    set_mode(2'd3);
    for (int f = 0; f < 8; f++) begin
      make_frame(0, f, 0, id, ext, rtr);
      send_check("R1 off", id, ext, rtr);
    end

    // R10: back-pressure holds the verdict and blocks input
    set_mode(2'd0);
    tbl[2] = {1'b0, 1'b0, 1'b0, 11'h5A3, 18'h0};
    cfg_write(4'd2, tbl[2]);
    tbl[0] = 32'hFFFF_FFFF;
    cfg_write(4'd0, tbl[0]);
    @(negedge clk);
    res_ready = 1'b0;
    in_valid = 1'b1; in_id = 29'h5A3; in_ext = 1'b0; in_rtr = 1'b0;
    @(negedge clk);
    in_id = 29'h123;                   // second frame, no match
    snap = {res_valid, res_accept, res_idx};
    check("R10 first", {snap, in_ready}, {1'b1, 1'b1, 5'd2, 1'b0});
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R10 hold", {res_valid, res_accept, res_idx, in_ready}, {snap, 1'b0});
    end
    res_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 next", {res_valid, res_accept, res_idx}, {1'b1, 1'b0, 5'd0});
    @(negedge clk);
    check("R9 drop", {res_valid, in_ready}, {1'b0, 1'b1});

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule